// File: doc/BRIEF.md
# Erase and Write-Protect Group Checker

This block is the checking side of a memory card's erase, block-write and write-protect-group commands. A controller passes each command to it as an opcode and a 32-bit argument. The block keeps the two erase bounds, a bitmap with one protect bit per group and a sticky "content altered" flag. It answers every command with a one-cycle completion pulse. Any status bits the command raises are valid on that pulse. Storage access, data transfer and response formatting belong to other blocks.

The card size comes in on a configuration input. A card larger than 2 GiB is treated as high capacity. On a high-capacity card, command arguments count 512-byte blocks, group protection is skipped entirely, and the three protect commands are rejected as illegal. On a standard card, arguments are byte addresses. A group index is the byte address shifted right by `GROUP_LOG2`.

The controller is a three-state machine:
- **IDLE** accepts a command.
- **SCAN** walks the group range of an erase on a standard card, one group per cycle.
- **RESP** raises the completion pulse.

The transitions are:
- IDLE→RESP for every command that needs no scan.
- IDLE→SCAN for a valid, in-range erase on a standard card whose start group is no higher than the clipped end group.
- SCAN→SCAN while groups remain, and SCAN→RESP on the last group.
- RESP→IDLE always.

Top module: `sdwp_check`

## Requirements
- R1: After reset `cmd_ready` is 1, `rsp_done` and every status output are 0, `copy_flag` is 0, no group is protected and both erase bounds are unset.
- R2: An erase-run command (opcode 2) issued while either bound is unset performs no erase. It completes with every status bit 0 and clears both bounds.
- R3: `high_cap` is 1 exactly when `cfg_card_bytes` exceeds 2^31. When `high_cap` is 1, every argument is multiplied by 512 to form a byte address; otherwise the argument is the byte address. Bound set commands are opcode 0 (start) and 1 (end).
- R4: If the scaled start or end bound is strictly greater than `cfg_card_bytes`, an erase-run raises `rsp_out_of_range`, does not erase and clears both bounds.
- R5: A successful erase-run raises `rsp_erased`, clears both bounds so that a following erase-run does nothing, and sets `copy_flag`. `copy_flag` stays set until reset.
- R6: On a standard card, a successful erase inspects every group from the start group to the end group inclusive, with the end clipped to the last group. It raises `rsp_erase_skip` if any of them is protected. It completes 1 + (groups inspected) cycles after acceptance. On a high-capacity card it never raises the skip bit and completes after 1 cycle.
- R7: A write-open command (opcode 3) whose scaled address plus `cfg_blk_len` is strictly greater than `cfg_card_bytes` raises `rsp_addr_err` and no write-protect status.
- R8: A write-open that is in range raises `rsp_wp_viol` in either of two cases: the card is standard and the group holding its address is protected, or either bit of `cfg_wp_lock` is set (on any card).
- R9: A next-block command (opcode 4) raises `rsp_wp_viol` only on a standard card whose addressed group is protected. `cfg_wp_lock` and a high-capacity card never raise it.
- R10: On a high-capacity card, protect-set (5), protect-clear (6) and protect-read (7) raise `rsp_illegal` and leave the bitmap unchanged.
- R11: On a standard card, protect-set and protect-clear with a byte address at or above `cfg_card_bytes` raise `rsp_addr_err` and change nothing. Otherwise they set or clear the addressed group's bit.
- R12: A protect-read on a standard card returns `rsp_prot_word`. Bit i of that word is the protect bit of group (addressed group + i). Groups past the last group read as 0.
- R13: Every command except an erase-run completes exactly one cycle after acceptance. `rsp_done` lasts one cycle, and `cmd_ready` is 0 from acceptance to completion. A command presented while `cmd_ready` is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_card_bytes | input | ARG_W+9 | Card size in bytes |
| cfg_blk_len | input | BLK_W | Write block length in bytes |
| cfg_wp_lock | input | 2 | Whole-card protect bits (permanent, temporary) |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command opcode |
| cmd_arg | input | ARG_W | Command argument |
| cmd_ready | output | 1 | Block is idle and accepts a command |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_out_of_range | output | 1 | Erase bound beyond card size |
| rsp_addr_err | output | 1 | Address error |
| rsp_wp_viol | output | 1 | Write-protect violation |
| rsp_erase_skip | output | 1 | Erase covered a protected group |
| rsp_illegal | output | 1 | Command not legal for this card |
| rsp_erased | output | 1 | Erase performed |
| rsp_prot_word | output | 32 | Protect bits returned by protect-read |
| copy_flag | output | 1 | Sticky content-altered flag |
| high_cap | output | 1 | Card is high capacity |

## Verification
The assertions check the following on every cycle:
- the completion protocol: the one-cycle pulse, the one-cycle turnaround and the busy window;
- the exclusions between status bits: out of range never with an erase, an address error never with a write-protect violation, erase skip only on a standard card that erased;
- that the illegal bit appears only on high-capacity cards;
- that the content-altered flag is sticky.

Only the bench scenarios can show the rest:
- which group the address scaling selects;
- the inclusive, clipped scan and its latency;
- the size boundaries at exactly the card size;
- bitmap contents after ignored or rejected commands;
- the bypass of group checks on high-capacity cards.

// File: rtl/sdwp_pkg.sv
package sdwp_pkg;

    typedef enum logic [2:0] {
        OP_ERASE_FROM = 3'd0,
        OP_ERASE_TO   = 3'd1,
        OP_ERASE_RUN  = 3'd2,
        OP_WRITE_OPEN = 3'd3,
        OP_WRITE_NEXT = 3'd4,
        OP_PROT_SET   = 3'd5,
        OP_PROT_CLR   = 3'd6,
        OP_PROT_READ  = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_RESP = 2'd2
    } state_e;

    typedef struct packed {
        logic out_of_range;
        logic addr_err;
        logic wp_viol;
        logic erase_skip;
        logic illegal;
        logic erased;
    } flags_t;

    localparam int HC_LIMIT_LOG2 = 31;
    localparam int BLOCK_LOG2    = 9;

endpackage

// File: rtl/sdwp_addr_scale.sv
module sdwp_addr_scale import sdwp_pkg::*; #(
    parameter int ARG_W     = 32,
    parameter int ADDR_W    = ARG_W + BLOCK_LOG2,
    parameter bit INCLUSIVE = 1'b0
) (
    input  logic [ARG_W-1:0]  arg_i,
    input  logic              high_cap_i,
    input  logic [ADDR_W-1:0] size_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              beyond_o
);

    assign addr_o = high_cap_i ? (ADDR_W'(arg_i) << BLOCK_LOG2) : ADDR_W'(arg_i);

    generate
        if (INCLUSIVE) begin : g_ge
            assign beyond_o = (addr_o >= size_i);
        end else begin : g_gt
            assign beyond_o = (addr_o > size_i);
        end
    endgenerate

endmodule

// File: rtl/sdwp_grpmap.sv
module sdwp_grpmap #(
    parameter int NUM_GROUPS = 512,
    parameter int GIDX_W     = 19,
    parameter int WIN_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_i,
    input  logic              clr_i,
    input  logic [GIDX_W-1:0] idx_cmd_i,
    input  logic [GIDX_W-1:0] idx_scan_i,
    output logic              hit_cmd_o,
    output logic              hit_scan_o,
    output logic [WIN_W-1:0]  win_o
);

    localparam int MAP_IW = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;

    logic [NUM_GROUPS-1:0] map_q;

    function automatic logic look(input logic [GIDX_W:0] idx,
                                  input logic [NUM_GROUPS-1:0] m);
        if (idx < (GIDX_W+1)'(NUM_GROUPS)) begin
            return m[idx[MAP_IW-1:0]];
        end
        return 1'b0;
    endfunction

    generate
        for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_bit
            logic sel;
            assign sel = (idx_cmd_i == GIDX_W'(g));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    map_q[g] <= 1'b0;
                end else if (sel && set_i) begin
                    map_q[g] <= 1'b1;
                end else if (sel && clr_i) begin
                    map_q[g] <= 1'b0;
                end
            end
        end

        for (genvar i = 0; i < WIN_W; i++) begin : g_win
            assign win_o[i] = look({1'b0, idx_cmd_i} + (GIDX_W+1)'(i), map_q);
        end
    endgenerate

    assign hit_cmd_o  = look({1'b0, idx_cmd_i}, map_q);
    assign hit_scan_o = look({1'b0, idx_scan_i}, map_q);

endmodule

// File: rtl/sdwp_check.sv
module sdwp_check import sdwp_pkg::*; #(
    parameter int ARG_W      = 32,
    parameter int GROUP_LOG2 = 22,
    parameter int NUM_GROUPS = 512,
    parameter int BLK_W      = 12,
    localparam int ADDR_W    = ARG_W + BLOCK_LOG2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_card_bytes,
    input  logic [BLK_W-1:0]  cfg_blk_len,
    input  logic [1:0]        cfg_wp_lock,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ARG_W-1:0]  cmd_arg,
    output logic              cmd_ready,
    output logic              rsp_done,
    output logic              rsp_out_of_range,
    output logic              rsp_addr_err,
    output logic              rsp_wp_viol,
    output logic              rsp_erase_skip,
    output logic              rsp_illegal,
    output logic              rsp_erased,
    output logic [31:0]       rsp_prot_word,
    output logic              copy_flag,
    output logic              high_cap
);

    localparam int GIDX_W = ADDR_W - GROUP_LOG2;
    localparam int WIN_W  = 32;
    localparam logic [ADDR_W-1:0] HC_LIMIT = ADDR_W'(1) << HC_LIMIT_LOG2;
    localparam logic [GIDX_W-1:0] LAST_GRP = GIDX_W'(NUM_GROUPS - 1);

    state_e st_q, st_nxt;
    op_e    op;
    flags_t flags_q;

    logic              accept;
    logic [ARG_W-1:0]  ers_from_q, ers_to_q;
    logic              from_vld_q, to_vld_q;
    logic [GIDX_W-1:0] scan_idx_q, scan_last_q;
    logic [WIN_W-1:0]  prot_q;
    logic              copy_q;

    logic [ARG_W-1:0]  raw_arg   [3];
    logic [ADDR_W-1:0] byte_addr [3];
    logic              beyond    [3];
    logic [GIDX_W-1:0] grp       [3];

    logic [ADDR_W:0]   wr_end;
    logic              wr_over;
    logic [GIDX_W-1:0] scan_end;
    logic              scan_needed;
    logic              ers_ok;
    logic              map_set, map_clr;
    logic              hit_cmd, hit_scan;
    logic [WIN_W-1:0]  win;

    assign high_cap  = (cfg_card_bytes > HC_LIMIT);
    assign cmd_ready = (st_q == ST_IDLE);
    assign accept    = cmd_valid && cmd_ready;
    assign op        = op_e'(cmd_op);

    // Slot 0: command argument, slot 1: erase start, slot 2: erase end.
    assign raw_arg[0] = cmd_arg;
    assign raw_arg[1] = ers_from_q;
    assign raw_arg[2] = ers_to_q;

    generate
        for (genvar k = 0; k < 3; k++) begin : g_addr
            sdwp_addr_scale #(
                .ARG_W     (ARG_W),
                .ADDR_W    (ADDR_W),
                .INCLUSIVE (k == 0)
            ) u_scale (
                .arg_i      (raw_arg[k]),
                .high_cap_i (high_cap),
                .size_i     (cfg_card_bytes),
                .addr_o     (byte_addr[k]),
                .beyond_o   (beyond[k])
            );
            assign grp[k] = GIDX_W'(byte_addr[k] >> GROUP_LOG2);
        end
    endgenerate

    assign wr_end      = {1'b0, byte_addr[0]} + (ADDR_W+1)'(cfg_blk_len);
    assign wr_over     = (wr_end > {1'b0, cfg_card_bytes});
    assign scan_end    = (grp[2] > LAST_GRP) ? LAST_GRP : grp[2];
    assign scan_needed = (grp[1] <= scan_end);
    assign ers_ok      = from_vld_q && to_vld_q && !beyond[1] && !beyond[2];

    assign map_set = accept && (op == OP_PROT_SET) && !high_cap && !beyond[0];
    assign map_clr = accept && (op == OP_PROT_CLR) && !high_cap && !beyond[0];

    sdwp_grpmap #(
        .NUM_GROUPS (NUM_GROUPS),
        .GIDX_W     (GIDX_W),
        .WIN_W      (WIN_W)
    ) u_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (map_set),
        .clr_i      (map_clr),
        .idx_cmd_i  (grp[0]),
        .idx_scan_i (scan_idx_q),
        .hit_cmd_o  (hit_cmd),
        .hit_scan_o (hit_scan),
        .win_o      (win)
    );

    // Next-state logic.
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (accept) begin
                    if (op == OP_ERASE_RUN && ers_ok && !high_cap && scan_needed) begin
                        st_nxt = ST_SCAN;
                    end else begin
                        st_nxt = ST_RESP;
                    end
                end
            end
            ST_SCAN: begin
                if (scan_idx_q == scan_last_q) begin
                    st_nxt = ST_RESP;
                end
            end
            ST_RESP: st_nxt = ST_IDLE;
            default: st_nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_nxt;
        end
    end

    // Bound, scan and response registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ers_from_q  <= '0;
            ers_to_q    <= '0;
            from_vld_q  <= 1'b0;
            to_vld_q    <= 1'b0;
            scan_idx_q  <= '0;
            scan_last_q <= '0;
            flags_q     <= '0;
            prot_q      <= '0;
            copy_q      <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        flags_q <= '0;
                        prot_q  <= '0;
                        unique case (op)
                            OP_ERASE_FROM: begin
                                ers_from_q <= cmd_arg;
                                from_vld_q <= 1'b1;
                            end
                            OP_ERASE_TO: begin
                                ers_to_q <= cmd_arg;
                                to_vld_q <= 1'b1;
                            end
                            OP_ERASE_RUN: begin
                                from_vld_q <= 1'b0;
                                to_vld_q   <= 1'b0;
                                if (from_vld_q && to_vld_q) begin
                                    if (beyond[1] || beyond[2]) begin
                                        flags_q.out_of_range <= 1'b1;
                                    end else begin
                                        flags_q.erased <= 1'b1;
                                        copy_q         <= 1'b1;
                                        scan_idx_q     <= grp[1];
                                        scan_last_q    <= scan_end;
                                    end
                                end
                            end
                            OP_WRITE_OPEN: begin
                                if (wr_over) begin
                                    flags_q.addr_err <= 1'b1;
                                end else if ((!high_cap && hit_cmd) || (|cfg_wp_lock)) begin
                                    flags_q.wp_viol <= 1'b1;
                                end
                            end
                            OP_WRITE_NEXT: begin
                                if (!high_cap && hit_cmd) begin
                                    flags_q.wp_viol <= 1'b1;
                                end
                            end
                            OP_PROT_SET, OP_PROT_CLR: begin
                                if (high_cap) begin
                                    flags_q.illegal <= 1'b1;
                                end else if (beyond[0]) begin
                                    flags_q.addr_err <= 1'b1;
                                end
                            end
                            OP_PROT_READ: begin
                                if (high_cap) begin
                                    flags_q.illegal <= 1'b1;
                                end else begin
                                    prot_q <= win;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
                ST_SCAN: begin
                    if (hit_scan) begin
                        flags_q.erase_skip <= 1'b1;
                    end
                    scan_idx_q <= scan_idx_q + 1'b1;
                end
                ST_RESP: ;
                default: ;
            endcase
        end
    end

    assign rsp_done         = (st_q == ST_RESP);
    assign rsp_out_of_range = rsp_done && flags_q.out_of_range;
    assign rsp_addr_err     = rsp_done && flags_q.addr_err;
    assign rsp_wp_viol      = rsp_done && flags_q.wp_viol;
    assign rsp_erase_skip   = rsp_done && flags_q.erase_skip;
    assign rsp_illegal      = rsp_done && flags_q.illegal;
    assign rsp_erased       = rsp_done && flags_q.erased;
    assign rsp_prot_word    = rsp_done ? prot_q : '0;
    assign copy_flag        = copy_q;

endmodule

// File: rtl/sdwp_check_sva.sv
module sdwp_check_sva import sdwp_pkg::*; (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [2:0] cmd_op,
    input logic       cmd_ready,
    input logic       rsp_done,
    input logic       rsp_out_of_range,
    input logic       rsp_addr_err,
    input logic       rsp_wp_viol,
    input logic       rsp_erase_skip,
    input logic       rsp_illegal,
    input logic       rsp_erased,
    input logic       copy_flag,
    input logic       high_cap
);

    logic any_flag;
    assign any_flag = rsp_out_of_range | rsp_addr_err | rsp_wp_viol |
                      rsp_erase_skip | rsp_illegal | rsp_erased;

    assert_ack_next_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op != OP_ERASE_RUN) |=> rsp_done);

    assert_done_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> (!rsp_done && cmd_ready));

    assert_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> !cmd_ready);

    assert_flags_on_done_R13: assert property (@(posedge clk) disable iff (!rst_n)
        any_flag |-> rsp_done);

    assert_illegal_hc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_illegal |-> high_cap);

    assert_skip_sc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_erase_skip |-> (rsp_erased && !high_cap));

    assert_oor_no_erase_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_out_of_range |-> !rsp_erased);

    assert_copy_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        copy_flag |=> copy_flag);

    assert_copy_on_erase_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_erased |-> copy_flag);

    assert_err_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_addr_err |-> !rsp_wp_viol);

endmodule

bind sdwp_check sdwp_check_sva u_sva (
    .clk              (clk),
    .rst_n            (rst_n),
    .cmd_valid        (cmd_valid),
    .cmd_op           (cmd_op),
    .cmd_ready        (cmd_ready),
    .rsp_done         (rsp_done),
    .rsp_out_of_range (rsp_out_of_range),
    .rsp_addr_err     (rsp_addr_err),
    .rsp_wp_viol      (rsp_wp_viol),
    .rsp_erase_skip   (rsp_erase_skip),
    .rsp_illegal      (rsp_illegal),
    .rsp_erased       (rsp_erased),
    .copy_flag        (copy_flag),
    .high_cap         (high_cap)
);

// File: tb/sdwp_check_tb.sv
module sdwp_check_tb;
    import sdwp_pkg::*;

    localparam int ARG_W  = 32;
    localparam int GLOG   = 12;
    localparam int NGRP   = 64;
    localparam int BLK_W  = 12;
    localparam int ADDR_W = ARG_W + 9;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] cfg_card_bytes = ADDR_W'(262144);
    logic [BLK_W-1:0]  cfg_blk_len = BLK_W'(512);
    logic [1:0]        cfg_wp_lock = 2'b00;
    logic              cmd_valid = 1'b0;
    logic [2:0]        cmd_op = 3'd0;
    logic [ARG_W-1:0]  cmd_arg = '0;
    logic              cmd_ready, rsp_done, rsp_out_of_range, rsp_addr_err;
    logic              rsp_wp_viol, rsp_erase_skip, rsp_illegal, rsp_erased;
    logic [31:0]       rsp_prot_word;
    logic              copy_flag, high_cap;

    always #2.5 clk = ~clk;

    sdwp_check #(
        .ARG_W      (ARG_W),
        .GROUP_LOG2 (GLOG),
        .NUM_GROUPS (NGRP),
        .BLK_W      (BLK_W)
    ) u_dut (
        .clk, .rst_n, .cfg_card_bytes, .cfg_blk_len, .cfg_wp_lock,
        .cmd_valid, .cmd_op, .cmd_arg, .cmd_ready, .rsp_done,
        .rsp_out_of_range, .rsp_addr_err, .rsp_wp_viol, .rsp_erase_skip,
        .rsp_illegal, .rsp_erased, .rsp_prot_word, .copy_flag, .high_cap
    );

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  summary_done = 0;

    // Behavioural reference state.
    bit [63:0] prot_m;
    bit        fv_m, tv_m, copy_m;
    longint    from_m, to_m;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!summary_done) begin
            summary_done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        end
    endtask

    function automatic bit is_hc();
        return longint'(cfg_card_bytes) > 64'h8000_0000;
    endfunction

    function automatic longint scale(input longint a);
        return is_hc() ? a * 512 : a;
    endfunction

    function automatic bit prot_at(input longint g);
        if (g < NGRP) return prot_m[g];
        return 1'b0;
    endfunction

    task automatic run_cmd(input op_e op, input longint arg, input string req, input bit inject = 0);
        longint card, a, s, e, gs, ge;
        int     exp_lat, lat;
        bit     x_oor, x_ae, x_wp, x_sk, x_il, x_er;
        logic [31:0] x_win;
        card = longint'(cfg_card_bytes);
        a = scale(arg);
        exp_lat = 1;
        {x_oor, x_ae, x_wp, x_sk, x_il, x_er} = '0;
        x_win = '0;
        case (op)
            OP_ERASE_FROM: begin from_m = arg; fv_m = 1; end
            OP_ERASE_TO:   begin to_m = arg; tv_m = 1; end
            OP_ERASE_RUN: begin
                if (fv_m && tv_m) begin
                    s = scale(from_m);
                    e = scale(to_m);
                    if (s > card || e > card) x_oor = 1;
                    else begin
                        x_er = 1;
                        copy_m = 1;
                        if (!is_hc()) begin
                            gs = s >> GLOG;
                            ge = e >> GLOG;
                            if (ge > NGRP - 1) ge = NGRP - 1;
                            for (longint g = gs; g <= ge; g++) if (prot_at(g)) x_sk = 1;
                            if (gs <= ge) exp_lat = 1 + int'(ge - gs + 1);
                        end
                    end
                end
                fv_m = 0;
                tv_m = 0;
            end
            OP_WRITE_OPEN: begin
                if (a + longint'(cfg_blk_len) > card) x_ae = 1;
                else if ((!is_hc() && prot_at(a >> GLOG)) || cfg_wp_lock != 0) x_wp = 1;
            end
            OP_WRITE_NEXT: begin
                if (!is_hc() && prot_at(a >> GLOG)) x_wp = 1;
            end
            OP_PROT_SET, OP_PROT_CLR: begin
                if (is_hc()) x_il = 1;
                else if (a >= card) x_ae = 1;
                else if ((a >> GLOG) < NGRP) prot_m[a >> GLOG] = (op == OP_PROT_SET);
            end
            OP_PROT_READ: begin
                if (is_hc()) x_il = 1;
                else for (int i = 0; i < 32; i++) x_win[i] = prot_at((a >> GLOG) + i);
            end
            default: ;
        endcase

        chk(cmd_ready === 1'b1, {req, "/R13 ready before issue"}, cmd_ready, 1);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_arg   = ARG_W'(arg);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        lat = 1;
        if (inject && exp_lat > 2) begin
            chk(cmd_ready === 1'b0, "R13 busy during scan", cmd_ready, 0);
            cmd_valid = 1'b1;
            cmd_op    = OP_PROT_SET;
            cmd_arg   = 32'h14000;
            @(negedge clk);
            cmd_valid = 1'b0;
            lat++;
        end
        while (rsp_done !== 1'b1 && lat < 300) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == exp_lat, {req, " latency"}, lat, exp_lat);
        chk(rsp_out_of_range === x_oor, {req, " out_of_range"}, rsp_out_of_range, x_oor);
        chk(rsp_addr_err === x_ae, {req, " addr_err"}, rsp_addr_err, x_ae);
        chk(rsp_wp_viol === x_wp, {req, " wp_viol"}, rsp_wp_viol, x_wp);
        chk(rsp_erase_skip === x_sk, {req, " erase_skip"}, rsp_erase_skip, x_sk);
        chk(rsp_illegal === x_il, {req, " illegal"}, rsp_illegal, x_il);
        chk(rsp_erased === x_er, {req, " erased"}, rsp_erased, x_er);
        chk(rsp_prot_word === x_win, {req, " prot_word"}, rsp_prot_word, x_win);
        chk(copy_flag === copy_m, {req, " copy_flag"}, copy_flag, copy_m);
        @(negedge clk);
        chk(rsp_done === 1'b0, "R13 done lasts one cycle", rsp_done, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        prot_m = '0; fv_m = 0; tv_m = 0; copy_m = 0; from_m = 0; to_m = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(cmd_ready === 1'b1, "R1 ready", cmd_ready, 1);
        chk(rsp_done === 1'b0, "R1 done", rsp_done, 0);
        chk(copy_flag === 1'b0, "R1 copy_flag", copy_flag, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_ready === 1'b1 && rsp_done === 1'b0, "R1 idle after reset", rsp_done, 0);
        chk(high_cap === 1'b0, "R3 standard card", high_cap, 0);

        run_cmd(OP_ERASE_RUN, 0, "R2 erase with bounds unset");
        run_cmd(OP_PROT_READ, 0, "R1 map clear");

        run_cmd(OP_PROT_SET, 32'h5000, "R11 set group 5");
        run_cmd(OP_PROT_SET, 32'h9000, "R11 set group 9");
        run_cmd(OP_PROT_SET, 32'h3F800, "R11 set group 63");
        run_cmd(OP_PROT_READ, 0, "R12 window from 0");
        run_cmd(OP_PROT_READ, 32'h3F000, "R12 window past end");
        run_cmd(OP_PROT_SET, 32'h40000, "R11 set at card size");
        run_cmd(OP_PROT_READ, 32'h20000, "R11 map unchanged");

        run_cmd(OP_ERASE_FROM, 32'h1000, "R5 bound start");
        run_cmd(OP_ERASE_TO, 32'h4FFF, "R5 bound end");
        run_cmd(OP_ERASE_RUN, 0, "R6 erase groups 1-4");
        run_cmd(OP_ERASE_RUN, 0, "R5 bounds cleared after erase");

        run_cmd(OP_ERASE_FROM, 32'h4000, "R6 bound start");
        run_cmd(OP_ERASE_TO, 32'h6000, "R6 bound end");
        run_cmd(OP_ERASE_RUN, 0, "R6 erase hits group 5", 1);
        run_cmd(OP_PROT_READ, 32'h14000, "R13 busy command ignored");

        run_cmd(OP_ERASE_FROM, 0, "R4 bound start");
        run_cmd(OP_ERASE_TO, 32'h40001, "R4 bound end");
        run_cmd(OP_ERASE_RUN, 0, "R4 end beyond size");
        run_cmd(OP_ERASE_RUN, 0, "R4 bounds cleared");

        run_cmd(OP_ERASE_FROM, 32'h40000, "R6 bound at size");
        run_cmd(OP_ERASE_TO, 32'h40000, "R6 bound at size");
        run_cmd(OP_ERASE_RUN, 0, "R6 range clipped to nothing");
        run_cmd(OP_ERASE_TO, 32'h2000, "R2 only end set");
        run_cmd(OP_ERASE_RUN, 0, "R2 erase with start unset");

        run_cmd(OP_PROT_CLR, 32'h5000, "R11 clear group 5");
        run_cmd(OP_PROT_READ, 0, "R12 window after clear");

        run_cmd(OP_WRITE_OPEN, 32'h9000, "R8 write to protected group");
        run_cmd(OP_WRITE_OPEN, 32'h3FE00, "R7 block ends at size");
        run_cmd(OP_WRITE_OPEN, 32'h3FE01, "R7 block past size");
        run_cmd(OP_WRITE_OPEN, 32'h1000, "R8 write unprotected");
        run_cmd(OP_WRITE_NEXT, 32'h9100, "R9 next block protected");
        run_cmd(OP_WRITE_NEXT, 32'h1000, "R9 next block free");
        cfg_wp_lock = 2'b01;
        run_cmd(OP_WRITE_OPEN, 32'h1000, "R8 lock bit 0");
        run_cmd(OP_WRITE_NEXT, 32'h1000, "R9 lock ignored on next block");
        cfg_wp_lock = 2'b10;
        run_cmd(OP_WRITE_OPEN, 32'h2000, "R8 lock bit 1");
        cfg_wp_lock = 2'b00;

        cfg_card_bytes = ADDR_W'(64'h1_0000_0000);
        @(negedge clk);
        chk(high_cap === 1'b1, "R3 high capacity above 2 GiB", high_cap, 1);
        run_cmd(OP_PROT_SET, 32'h10, "R10 set illegal");
        run_cmd(OP_PROT_CLR, 32'h48, "R10 clear illegal");
        run_cmd(OP_PROT_READ, 0, "R10 read illegal");
        run_cmd(OP_WRITE_OPEN, 32'h48, "R8 high capacity skips groups");
        run_cmd(OP_WRITE_NEXT, 32'h48, "R9 high capacity skips groups");
        run_cmd(OP_WRITE_OPEN, 32'h7F_FFFF, "R3 scaled write at size");
        run_cmd(OP_WRITE_OPEN, 32'h80_0000, "R3 scaled write past size");
        cfg_wp_lock = 2'b10;
        run_cmd(OP_WRITE_OPEN, 32'h48, "R8 lock on high capacity");
        cfg_wp_lock = 2'b00;
        run_cmd(OP_ERASE_FROM, 0, "R6 bound start");
        run_cmd(OP_ERASE_TO, 100, "R6 bound end");
        run_cmd(OP_ERASE_RUN, 0, "R6 high capacity no scan");
        run_cmd(OP_ERASE_FROM, 0, "R4 bound start");
        run_cmd(OP_ERASE_TO, 32'h80_0001, "R4 scaled end past size");
        run_cmd(OP_ERASE_RUN, 0, "R4 scaled out of range");

        cfg_card_bytes = ADDR_W'(262144);
        @(negedge clk);
        chk(high_cap === 1'b0, "R3 back to standard", high_cap, 0);
        run_cmd(OP_PROT_READ, 0, "R10 map unchanged by illegal");

        summary();
        $finish;
    end

endmodule